// File: doc/BRIEF.md
# Carry-Save Reduction Tree of 4:2 Compressors

This block is the accumulation stage of a radix-4 recoded multiplier. For an N-bit operand pair a recoder outside the block produces N/2+1 partial-product rows. Each row is already shifted to its place and sign-extended to the full 2N-bit product width. The block is purely combinational. It sums these rows in carry-save form with a tree of 4:2 compressor cells, so that each level of the tree halves the number of rows. A final 2N-bit carry-propagate addition then turns the two remaining rows into the product.

Each compressor cell takes four operand bits and a carry from the column on its right. It returns a sum bit, a carry bit for the next column, and a transfer bit that becomes the incoming carry of the next column's cell. The transfer bit is formed from three operand bits only, so no carry travels more than one column inside a level. The cell builds its carry from a three-input XOR term and the complement of that term, which selects between an AND and an OR of the other two inputs. A level whose row count is not a multiple of four sends three leftover rows through a row of 3:2 counters. It passes one or two leftover rows on to the next level unchanged.

Top module: `ctree_booth_reduce`

## Requirements
- R1: Each compressor cell drives its sum bit high exactly when an odd number of its five inputs (a, b, c, d, carry-in) are high.
- R2: Each cell drives its transfer-out bit high exactly when at least two of a, b and c are high; d and carry-in have no effect on it.
- R3: For every input pattern of a cell, a+b+c+d+cin equals sum + 2*(carry + transfer-out).
- R4: Each cell drives its carry bit high exactly when at least two of {a XOR b XOR c, d, carry-in} are high.
- R5: The two output rows satisfy sum_row_o + carry_row_o = (sum of all input rows) modulo 2^(2N).
- R6: product_o equals the sum of all input rows modulo 2^(2N).
- R7: There are N/2+1 input rows. Row k occupies bits [k*2N +: 2N] of rows_i, and every row, the last one included, counts with weight one at its own bit positions.
- R8: The carry into column 0 is zero, and anything carried out of column 2N-1 is dropped, so sums wrap modulo 2^(2N).
- R9: When the rows are the radix-4 recoded partial products of unsigned operands A and B, product_o equals A*B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rows_i | input | (N/2+1)*2N | Aligned partial-product rows, row k in bits [k*2N +: 2N] |
| sum_row_o | output | 2N | Sum row left after the tree |
| carry_row_o | output | 2N | Carry row left after the tree, already shifted to its weight |
| product_o | output | 2N | Sum of the two rows, modulo 2^(2N) |

## Verification
The cell is driven through all 32 input patterns. This separates a wrong parity, a wrong carry select and a transfer bit that leaks carry-in. The full tree first sees fixed row sets. All-zero rows, one per row, and a single row in the last slot show whether the packing and the odd-row path are right. All-ones and sign-bit rows check that overflow wraps. A long carry chain tests the final adder, and interleaved alternating patterns cross every column. Pseudo-random row sets then give many carry combinations, and real radix-4 partial products of random operands must give the exact product.

// File: rtl/ctree_pkg.sv
package ctree_pkg;

    // Outputs of one 4:2 compressor cell.
    typedef struct packed {
        logic sum;
        logic carry;
        logic cout;
    } c42_out_t;

    // Rows left after one reduction level: each group of four becomes two,
    // a leftover of three becomes two, a leftover of one or two passes.
    function automatic int rows_after(int k);
        return 2 * (k / 4) + (((k % 4) == 3) ? 2 : (k % 4));
    endfunction

    function automatic int rows_at(int r0, int lvl);
        int k;
        k = r0;
        for (int i = 0; i < lvl; i++) k = rows_after(k);
        return k;
    endfunction

    function automatic int level_count(int r0);
        int k;
        int n;
        k = r0;
        n = 0;
        while (k > 2) begin
            k = rows_after(k);
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/ctree_c42_cell.sv
module ctree_c42_cell
    import ctree_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     c_i,
    input  logic     d_i,
    input  logic     cin_i,
    output c42_out_t res_o
);
    logic ab_x;
    logic cd_x;
    logic h;
    logic g;

    assign ab_x = a_i ^ b_i;
    assign cd_x = c_i ^ d_i;
    assign h    = ab_x ^ c_i;
    assign g    = ~h;

    // Sum path: two XOR levels in parallel, then one more with cin.
    assign res_o.sum   = (ab_x ^ cd_x) ^ cin_i;
    // Carry from the three-input XOR term and its complement.
    assign res_o.carry = g ? (d_i & cin_i) : (d_i | cin_i);
    // Transfer bit: independent of cin_i.
    assign res_o.cout  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/ctree_c42_row.sv
module ctree_c42_row
    import ctree_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] r0_i,
    input  logic [W-1:0] r1_i,
    input  logic [W-1:0] r2_i,
    input  logic [W-1:0] r3_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    c42_out_t   res [W];
    logic [W:0] link;
    logic       unused_spill;

    assign link[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        ctree_c42_cell u_cell (
            .a_i  (r0_i[i]),
            .b_i  (r1_i[i]),
            .c_i  (r2_i[i]),
            .d_i  (r3_i[i]),
            .cin_i(link[i]),
            .res_o(res[i])
        );
        assign link[i+1] = res[i].cout;
        assign sum_o[i]  = res[i].sum;
        if (i == 0) begin : g_lsb
            assign carry_o[0] = 1'b0;
        end else begin : g_up
            assign carry_o[i] = res[i-1].carry;
        end
    end

    assign unused_spill = link[W] ^ res[W-1].carry;
endmodule

// File: rtl/ctree_fa_row.sv
module ctree_fa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] r0_i,
    input  logic [W-1:0] r1_i,
    input  logic [W-1:0] r2_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] maj;
    logic         unused_spill;

    assign sum_o   = r0_i ^ r1_i ^ r2_i;
    assign maj     = (r0_i & r1_i) | (r0_i & r2_i) | (r1_i & r2_i);
    assign carry_o = {maj[W-2:0], 1'b0};
    assign unused_spill = maj[W-1];
endmodule

// File: rtl/ctree_level.sv
module ctree_level #(
    parameter int W     = 16,
    parameter int IN_R  = 5,
    parameter int OUT_R = 3
) (
    input  logic [IN_R*W-1:0]  rows_i,
    output logic [OUT_R*W-1:0] rows_o
);
    localparam int NQ  = IN_R / 4;
    localparam int REM = IN_R % 4;

    for (genvar q = 0; q < NQ; q++) begin : g_quad
        ctree_c42_row #(.W(W)) u_row (
            .r0_i   (rows_i[(4*q+0)*W +: W]),
            .r1_i   (rows_i[(4*q+1)*W +: W]),
            .r2_i   (rows_i[(4*q+2)*W +: W]),
            .r3_i   (rows_i[(4*q+3)*W +: W]),
            .sum_o  (rows_o[(2*q+0)*W +: W]),
            .carry_o(rows_o[(2*q+1)*W +: W])
        );
    end

    if (REM == 3) begin : g_tri
        ctree_fa_row #(.W(W)) u_fa (
            .r0_i   (rows_i[(4*NQ+0)*W +: W]),
            .r1_i   (rows_i[(4*NQ+1)*W +: W]),
            .r2_i   (rows_i[(4*NQ+2)*W +: W]),
            .sum_o  (rows_o[(2*NQ+0)*W +: W]),
            .carry_o(rows_o[(2*NQ+1)*W +: W])
        );
    end else begin : g_pass
        for (genvar j = 0; j < REM; j++) begin : g_row
            assign rows_o[(2*NQ+j)*W +: W] = rows_i[(4*NQ+j)*W +: W];
        end
    end
endmodule

// File: rtl/ctree_booth_reduce.sv
module ctree_booth_reduce
    import ctree_pkg::*;
#(
    parameter  int N    = 8,
    localparam int W    = 2 * N,
    localparam int ROWS = N / 2 + 1
) (
    input  logic [ROWS*W-1:0] rows_i,
    output logic [W-1:0]      sum_row_o,
    output logic [W-1:0]      carry_row_o,
    output logic [W-1:0]      product_o
);
    localparam int LEVELS = level_count(ROWS);

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IN_R  = rows_at(ROWS, l);
        localparam int OUT_R = rows_at(ROWS, l + 1);
        logic [OUT_R*W-1:0] r_out;
        if (l == 0) begin : g_first
            ctree_level #(.W(W), .IN_R(IN_R), .OUT_R(OUT_R)) u_lvl (
                .rows_i(rows_i),
                .rows_o(r_out)
            );
        end else begin : g_next
            ctree_level #(.W(W), .IN_R(IN_R), .OUT_R(OUT_R)) u_lvl (
                .rows_i(g_lvl[l-1].r_out),
                .rows_o(r_out)
            );
        end
    end

    assign sum_row_o   = g_lvl[LEVELS-1].r_out[W-1:0];
    assign carry_row_o = g_lvl[LEVELS-1].r_out[2*W-1:W];
    assign product_o   = sum_row_o + carry_row_o;
endmodule

// File: rtl/ctree_chk.sv
module ctree_cell_chk
    import ctree_pkg::*;
(
    input logic     a_i,
    input logic     b_i,
    input logic     c_i,
    input logic     d_i,
    input logic     cin_i,
    input c42_out_t res_o
);
    int in_w;
    int out_w;
    always_comb begin
        in_w  = int'(a_i) + int'(b_i) + int'(c_i) + int'(d_i) + int'(cin_i);
        out_w = int'(res_o.sum) + 2 * (int'(res_o.carry) + int'(res_o.cout));
        assert_sum_parity_R1: assert (res_o.sum == in_w[0])
            else $error("cell sum parity wrong");
        assert_cout_majority_R2: assert (res_o.cout == ($countones({a_i, b_i, c_i}) >= 2))
            else $error("cell transfer bit wrong");
        assert_cell_weight_R3: assert (in_w == out_w)
            else $error("cell weight not preserved");
    end
endmodule

module ctree_chk #(
    parameter  int N    = 8,
    localparam int W    = 2 * N,
    localparam int ROWS = N / 2 + 1
) (
    input logic [ROWS*W-1:0] rows_i,
    input logic [W-1:0]      sum_row_o,
    input logic [W-1:0]      carry_row_o,
    input logic [W-1:0]      product_o
);
    logic [W-1:0] total;
    logic [W-1:0] pair;
    always_comb begin
        total = '0;
        for (int k = 0; k < ROWS; k++) total = total + rows_i[k*W +: W];
        pair = sum_row_o + carry_row_o;
        assert_rows_preserve_R5: assert (pair == total)
            else $error("reduced rows do not match input sum");
        assert_product_R6: assert (product_o == total)
            else $error("product does not match input sum");
    end
endmodule

bind ctree_c42_cell ctree_cell_chk u_cell_chk (
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (c_i),
    .d_i  (d_i),
    .cin_i(cin_i),
    .res_o(res_o)
);

bind ctree_booth_reduce ctree_chk #(.N(N)) u_chk (
    .rows_i     (rows_i),
    .sum_row_o  (sum_row_o),
    .carry_row_o(carry_row_o),
    .product_o  (product_o)
);

// File: tb/sim_ctree_booth_reduce.sv
module sim_ctree_booth_reduce;
    import ctree_pkg::*;

    localparam int N    = 8;
    localparam int W    = 2 * N;
    localparam int ROWS = N / 2 + 1;
    localparam int NV   = 9;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [ROWS*W-1:0] rows = '0;
    logic [W-1:0]      srow;
    logic [W-1:0]      crow;
    logic [W-1:0]      prod;

    ctree_booth_reduce #(.N(N)) u0 (
        .rows_i     (rows),
        .sum_row_o  (srow),
        .carry_row_o(crow),
        .product_o  (prod)
    );

    logic     ca = 1'b0, cb = 1'b0, cc = 1'b0, cd = 1'b0, ccin = 1'b0;
    c42_out_t cres;

    ctree_c42_cell u_cell (
        .a_i  (ca),
        .b_i  (cb),
        .c_i  (cc),
        .d_i  (cd),
        .cin_i(ccin),
        .res_o(cres)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Entry layout: {expected sum, row4, row3, row2, row1, row0}
    localparam logic [ROWS*W+W-1:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {16'h0005, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001},
        {16'hFFFB, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        {16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000},
        {16'h001F, 16'h0010, 16'h0008, 16'h0004, 16'h0002, 16'h0001},
        {16'h1234, 16'h0001, 16'h1234, 16'hF000, 16'h0F00, 16'h00FF},
        {16'hFFFF, 16'h0001, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555},
        {16'h8000, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'h7FFF},
        {16'hBEEF, 16'hBEEF, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_rows(input logic [ROWS*W-1:0] r);
        @(negedge clk);
        rows = r;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] row_total(input logic [ROWS*W-1:0] r);
        logic [W-1:0] t;
        t = '0;
        for (int k = 0; k < ROWS; k++) t = t + r[k*W +: W];
        return t;
    endfunction

    // Radix-4 recoded partial products of unsigned a, b.
    function automatic logic [ROWS*W-1:0] booth_rows(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [ROWS*W-1:0] r;
        logic [N+2:0]      bx;
        logic [2:0]        t;
        longint            v;
        int                dig;
        bx = {2'b00, b, 1'b0};
        r  = '0;
        for (int k = 0; k < ROWS; k++) begin
            t   = bx[2*k+2 -: 3];
            dig = -2 * int'(t[2]) + int'(t[1]) + int'(t[0]);
            v   = longint'(a) * longint'(dig);
            v   = v <<< (2 * k);
            r[k*W +: W] = v[W-1:0];
        end
        return r;
    endfunction

    logic [31:0] lfsr = 32'h1ACE_B00C;
    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // Quiet state: zero rows give zero everywhere (R6).
        @(posedge clk);
        #1;
        check("R6 idle product", prod, '0);
        check("R5 idle sum row", srow, '0);
        check("R5 idle carry row", crow, '0);

        // Exhaustive cell sweep (R1, R2, R3, R4).
        for (int v = 0; v < 32; v++) begin
            logic [4:0] p;
            logic       h;
            int         in_w;
            int         out_w;
            p = v[4:0];
            @(negedge clk);
            {ca, cb, cc, cd, ccin} = p;
            @(posedge clk);
            #1;
            h     = p[4] ^ p[3] ^ p[2];
            in_w  = $countones(p);
            out_w = int'(cres.sum) + 2 * (int'(cres.carry) + int'(cres.cout));
            check("R1 cell sum", {15'd0, cres.sum}, {15'd0, ^p});
            check("R2 cell transfer", {15'd0, cres.cout},
                  {15'd0, ($countones(p[4:2]) >= 2)});
            check("R3 cell weight", in_w[W-1:0], out_w[W-1:0]);
            check("R4 cell carry", {15'd0, cres.carry},
                  {15'd0, ($countones({h, p[1], p[0]}) >= 2)});
        end

        // Table of row sets: packing (R7), wrap (R8), sums (R5, R6).
        for (int i = 0; i < NV; i++) begin
            logic [ROWS*W+W-1:0] e;
            e = VEC[i];
            apply_rows(e[ROWS*W-1:0]);
            check("R6 table product", prod, e[ROWS*W +: W]);
            check("R5 table row pair", srow + crow, e[ROWS*W +: W]);
        end

        // Last-slot row alone must pass intact (R7); all-ones wrap (R8).
        apply_rows({16'h4321, {(ROWS-1)*W{1'b0}}});
        check("R7 last row weight", prod, 16'h4321);
        apply_rows({ROWS*W{1'b1}});
        check("R8 overflow wraps", prod, 16'hFFFB);

        // Pseudo-random row sets (R5, R6).
        for (int i = 0; i < 200; i++) begin
            logic [ROWS*W-1:0] r;
            for (int k = 0; k < ROWS; k++) begin
                lfsr = nxt(lfsr);
                r[k*W +: W] = lfsr[W-1:0] ^ lfsr[31:32-W];
            end
            apply_rows(r);
            check("R6 random product", prod, row_total(r));
            check("R5 random row pair", srow + crow, row_total(r));
        end

        // Radix-4 recoded operands (R9).
        for (int i = 0; i < 100; i++) begin
            logic [N-1:0] a;
            logic [N-1:0] b;
            logic [W-1:0] exp;
            lfsr = nxt(lfsr);
            a = lfsr[N-1:0];
            b = lfsr[2*N-1:N];
            if (i == 0) begin a = '1; b = '1; end
            if (i == 1) begin a = '1; b = {1'b1, {(N-1){1'b0}}}; end
            exp = W'(a) * W'(b);
            apply_rows(booth_rows(a, b));
            check("R9 recoded product", prod, exp);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule